// File: doc/BRIEF.md
# Sequential Fractional Signed Multiplier

This unit multiplies two two's-complement fractions of `W` bits (sign at the top bit, binary point just below it, so every operand lies in [-1, 1)) without any array multiplier. It examines one multiplier bit per cycle and adds the multiplicand to a running partial product, or subtracts it on the final step for the sign bit. After a fixed number of cycles it leaves a double-length result split across two working words. The high half goes to the accumulator output and the low half to the arithmetic-register output.

A start strobe captures the multiplicand word, the multiplier, the prior accumulator value and two mode flags. With the clear flag low, the prior accumulator value is added into the product at the high half. With the rounding flag high, the low half's top bit is folded into the high half and the low half is zeroed. Results that leave the representable double-length range saturate and raise an overflow flag. The multiplicand stays visible on a memory-word output from the moment it is captured.

Top module: `frac_seq_mul`

## Requirements
- R1: While and directly after a synchronous active-high reset, all outputs are 0: `acc_out`, `areg_out`, `mreg_out`, `done`, `ovf` and `busy`.
- R2: With `clr`=1 and `rnd`=0, `{acc_out, areg_out}` equals the signed integer product `mcand * mplier` shifted left by one. The result is a 2W-bit fraction with the sign in bit 2W-1, and `areg_out[0]` is 0 whenever `ovf` is 0.
- R3: With `clr`=0, the captured `acc_in`, weighted by 2^W, is added to the shifted product of R2.
- R4: With `rnd`=1, 2^(W-1) is added to the result of R2/R3, and `areg_out` then reads all zeros.
- R5: The operands -1 by -1 (both words `1` followed by zeros) give the largest positive value: `acc_out` = 0 then all ones, `areg_out` all ones, and `ovf`=1.
- R6: Any result above the largest positive value saturates as in R5. Any result below -1 saturates to `acc_out` = 1 then zeros, with `areg_out` all zeros. `ovf` is 1 only in these cases and 0 otherwise.
- R7: `done` is a single-cycle pulse in the W+1-th cycle after the clock edge that accepts `start`. `busy` is high from that edge until the edge that raises `done`.
- R8: `start` is ignored while `busy` is high. The operation in progress finishes with its own operands and produces exactly one `done`.
- R9: `mreg_out` takes the multiplicand at the accepting edge and holds it through and after the operation.
- R10: A `start` in the same cycle as `done` is accepted, and the next result follows W+1 cycles later.
- R11: `acc_out`, `areg_out` and `ovf` change only at the edge that raises `done`, and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation when idle |
| mcand | input | W | Multiplicand word |
| mplier | input | W | Multiplier (arithmetic-register contents) |
| acc_in | input | W | Prior accumulator value |
| clr | input | 1 | 1: ignore prior accumulator; 0: add it in |
| rnd | input | 1 | 1: round into high half |
| acc_out | output | W | High half of the result |
| areg_out | output | W | Low half of the result |
| mreg_out | output | W | Captured multiplicand |
| done | output | 1 | One-cycle completion pulse |
| ovf | output | 1 | Result was saturated |
| busy | output | 1 | Operation in progress |

## Verification
The completion pulse and the acceptance of a new start can fall in the same cycle. A bench task holds `start` high with fresh operands in the very cycle `done` is seen. It then judges the handover in three ways: the first result must be intact on that cycle, the new operation must not be lost, and its result and pulse must arrive exactly W+1 cycles later. A separate task raises `start` while busy and checks that the running result and its timing are unaffected.

// File: rtl/frac_mul_pkg.sv
package frac_mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mul_state_e;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import frac_mul_pkg::*;
#(
  parameter int W = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step_en,
  output logic last,
  output logic fin,
  output logic busy
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

  mul_state_e state_q;
  logic [CW-1:0] cnt_q;

  assign load    = start && (state_q == ST_IDLE);
  assign step_en = (state_q == ST_RUN);
  assign last    = step_en && (cnt_q == LAST_IDX);
  assign fin     = (state_q == ST_FIN);
  assign busy    = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_IDX) state_q <= ST_FIN;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mul_step.sv
module mul_step #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step_en,
  input  logic         last,
  input  logic [W-1:0] mplier,
  input  logic [W-1:0] mcand,
  output logic [2*W:0] prod,
  output logic [W-1:0] mcand_q
);
  localparam int PW = W + 1;

  logic [PW-1:0] ph_q;
  logic [W-1:0]  pl_q;
  logic [W-1:0]  b_q;
  logic [PW-1:0] b_ext;
  logic [PW-1:0] addend;
  logic [PW-1:0] sum;

  assign b_ext = {b_q[W-1], b_q};

  always_comb begin
    addend = '0;
    if (pl_q[0]) addend = last ? (~b_ext + 1'b1) : b_ext;
    sum = ph_q + addend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= '0;
      pl_q <= '0;
      b_q  <= '0;
    end else if (load) begin
      ph_q <= '0;
      pl_q <= mplier;
      b_q  <= mcand;
    end else if (step_en) begin
      ph_q <= {sum[PW-1], sum[PW-1:1]};
      pl_q <= {sum[0], pl_q[W-1:1]};
    end
  end

  assign prod    = {ph_q, pl_q};
  assign mcand_q = b_q;
endmodule

// File: rtl/mul_final.sv
module mul_final #(
  parameter int W = 40
) (
  input  logic [2*W:0]  prod,
  input  logic [W-1:0]  acc,
  input  logic          clr,
  input  logic          rnd,
  output logic [W-1:0]  hi,
  output logic [W-1:0]  lo,
  output logic          ovf
);
  localparam int XW = 2 * W + 3;
  localparam int TB = XW - (2 * W - 1);

  logic [XW-1:0] prod2;
  logic [XW-1:0] acc_w;
  logic [XW-1:0] s0;
  logic [XW-1:0] rs;
  logic [XW-1:0] s1;
  logic [TB-1:0] top;
  logic          in_range;

  always_comb begin
    prod2 = {prod[2*W], prod, 1'b0};
    acc_w = clr ? '0 : {{3{acc[W-1]}}, acc, {W{1'b0}}};
    s0    = prod2 + acc_w;
    rs    = s0 + {{(XW-W){1'b0}}, 1'b1, {(W-1){1'b0}}};
    s1    = rnd ? {rs[XW-1:W], {W{1'b0}}} : s0;
    top      = s1[XW-1:2*W-1];
    in_range = (&top) || !(|top);
    ovf      = !in_range;
    if (in_range) begin
      hi = s1[2*W-1:W];
      lo = s1[W-1:0];
    end else if (s1[XW-1]) begin
      hi = {1'b1, {(W-1){1'b0}}};
      lo = '0;
    end else begin
      hi = {1'b0, {(W-1){1'b1}}};
      lo = '1;
    end
  end
endmodule

// File: rtl/frac_seq_mul.sv
module frac_seq_mul #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplier,
  input  logic [W-1:0] acc_in,
  input  logic         clr,
  input  logic         rnd,
  output logic [W-1:0] acc_out,
  output logic [W-1:0] areg_out,
  output logic [W-1:0] mreg_out,
  output logic         done,
  output logic         ovf,
  output logic         busy
);
  logic         load;
  logic         step_en;
  logic         last;
  logic         fin;
  logic [2*W:0] prod;
  logic [W-1:0] acc_cap;
  logic         clr_cap;
  logic         rnd_cap;
  logic [W-1:0] res_hi;
  logic [W-1:0] res_lo;
  logic         res_ovf;

  mul_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .load(load),
    .step_en(step_en), .last(last), .fin(fin), .busy(busy)
  );

  mul_step #(.W(W)) u_step (
    .clk(clk), .rst(rst), .load(load), .step_en(step_en), .last(last),
    .mplier(mplier), .mcand(mcand), .prod(prod), .mcand_q(mreg_out)
  );

  mul_final #(.W(W)) u_final (
    .prod(prod), .acc(acc_cap), .clr(clr_cap), .rnd(rnd_cap),
    .hi(res_hi), .lo(res_lo), .ovf(res_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_cap  <= '0;
      clr_cap  <= 1'b0;
      rnd_cap  <= 1'b0;
      acc_out  <= '0;
      areg_out <= '0;
      ovf      <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= fin;
      if (load) begin
        acc_cap <= acc_in;
        clr_cap <= clr;
        rnd_cap <= rnd;
      end
      if (fin) begin
        acc_out  <= res_hi;
        areg_out <= res_lo;
        ovf      <= res_ovf;
      end
    end
  end
endmodule

// File: rtl/frac_seq_mul_chk.sv
module frac_seq_mul_chk #(
  parameter int W = 40
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         ovf,
  input logic [W-1:0] acc_out,
  input logic [W-1:0] areg_out,
  input logic [W-1:0] mreg_out
);
  localparam int LW = $clog2(W + 3);
  localparam logic [LW-1:0] LAT = LW'(W + 1);

  logic [LW-1:0] lat_q;

  always_ff @(posedge clk) begin
    if (rst) lat_q <= '0;
    else if (start && !busy) lat_q <= '0;
    else if (busy) lat_q <= lat_q + 1'b1;
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_q == LAT));

  p_idle_at_done_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_mreg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mreg_out));

  p_result_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(acc_out) && $stable(areg_out) && $stable(ovf)));

  p_sat_value_r6: assert property (@(posedge clk) disable iff (rst)
    ovf |-> ((acc_out == {1'b0, {(W-1){1'b1}}} && areg_out == '1) ||
             (acc_out == {1'b1, {(W-1){1'b0}}} && areg_out == '0)));

  p_lsb_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !ovf |-> !areg_out[0]);
endmodule

bind frac_seq_mul frac_seq_mul_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .ovf(ovf), .acc_out(acc_out), .areg_out(areg_out), .mreg_out(mreg_out)
);

// File: tb/frac_seq_mul_bench.sv
module frac_seq_mul_bench;
  localparam int W = 40;
  localparam int CLK_PERIOD = 10;
  localparam int XW = 2 * W + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] mcand = '0, mplier = '0, acc_in = '0;
  logic clr = 1'b1, rnd = 1'b0;
  logic [W-1:0] acc_out, areg_out, mreg_out;
  logic done, ovf, busy;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  localparam logic [W-1:0] NEG1 = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] HALF = {2'b01, {(W-2){1'b0}}};
  localparam logic [W-1:0] NHALF = {2'b11, {(W-2){1'b0}}};
  localparam logic [W-1:0] QTR = {3'b001, {(W-3){1'b0}}};
  localparam logic [W-1:0] ULP = {{(W-1){1'b0}}, 1'b1};

  frac_seq_mul #(.W(W)) u_frac_seq_mul (
    .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
    .acc_in(acc_in), .clr(clr), .rnd(rnd), .acc_out(acc_out),
    .areg_out(areg_out), .mreg_out(mreg_out), .done(done), .ovf(ovf),
    .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [2*W:0] act,
                       input logic [2*W:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic [W-1:0] a, b, c, input logic cl, rn,
                       output logic [W-1:0] hi, lo, output logic ov);
    logic signed [XW-1:0] sa, sb, sc, s, one, maxv, minv;
    sa = $signed(a);
    sb = $signed(b);
    sc = $signed(c);
    one = 1;
    s = (sa * sb) <<< 1;
    if (!cl) s = s + (sc <<< W);
    if (rn) begin
      s = s + (one <<< (W - 1));
      s[W-1:0] = '0;
    end
    maxv = (one <<< (2 * W - 1)) - one;
    minv = -(one <<< (2 * W - 1));
    ov = 1'b1;
    if (s > maxv) begin
      hi = MAXP; lo = '1;
    end else if (s < minv) begin
      hi = NEG1; lo = '0;
    end else begin
      hi = s[2*W-1:W]; lo = s[W-1:0]; ov = 1'b0;
    end
  endtask

  task automatic drive(input logic [W-1:0] a, b, c, input logic cl, rn);
    mcand = a; mplier = b; acc_in = c; clr = cl; rnd = rn; start = 1'b1;
  endtask

  // waits W+1 edges after the accepting edge, checking busy/done timing
  task automatic wait_result(input string req);
    bit early = 1'b0;
    for (int k = 1; k <= W + 1; k++) begin
      @(posedge clk); #1;
      if (k <= W && (done || !busy)) early = 1'b1;
    end
    check(!early, {req, " R7 busy high, done low during run"}, {early}, 0);
    check(done && !busy, {req, " R7 done after W+1 cycles"}, {done, busy}, 2);
  endtask

  task automatic check_result(input logic [W-1:0] a, b, c, input logic cl, rn,
                              input string req);
    logic [W-1:0] eh, el;
    logic eo;
    model(a, b, c, cl, rn, eh, el, eo);
    check({acc_out, areg_out} == {eh, el}, {req, " result"},
          {1'b0, acc_out, areg_out}, {1'b0, eh, el});
    check(ovf == eo, {req, " ovf"}, ovf, eo);
    check(mreg_out == a, {req, " R9 multiplicand held"}, mreg_out, a);
  endtask

  task automatic run_op(input logic [W-1:0] a, b, c, input logic cl, rn,
                        input string req);
    @(negedge clk);
    drive(a, b, c, cl, rn);
    @(posedge clk); #1;
    start = 1'b0;
    check(busy, {req, " R7 busy after accept"}, busy, 1);
    wait_result(req);
    check_result(a, b, c, cl, rn, req);
    @(posedge clk); #1;
    check(!done, {req, " R7 done lasts one cycle"}, done, 0);
  endtask

  task automatic t_reset();
    @(posedge clk); #1;
    check(acc_out == '0 && areg_out == '0 && mreg_out == '0 && !done && !ovf && !busy,
          "R1 reset state", {acc_out, areg_out}, 0);
  endtask

  task automatic t_products();
    run_op(HALF, HALF, '0, 1'b1, 1'b0, "R2 half*half");
    run_op(NHALF, HALF, '0, 1'b1, 1'b0, "R2 neg*pos");
    run_op(NHALF, NHALF, '0, 1'b1, 1'b0, "R2 neg*neg");
    run_op(MAXP, NEG1, '0, 1'b1, 1'b0, "R2 max*-1");
    run_op(MAXP, MAXP, '0, 1'b1, 1'b0, "R2 max*max");
    run_op('0, NEG1, '0, 1'b1, 1'b0, "R2 zero operand");
    for (int i = 0; i < 6; i++) begin
      logic [63:0] r1, r2;
      r1 = {$urandom(), $urandom()};
      r2 = {$urandom(), $urandom()};
      run_op(r1[W-1:0], r2[W-1:0], '0, 1'b1, 1'b0, "R2 mixed pattern");
    end
  endtask

  task automatic t_accumulate();
    run_op(HALF, HALF, QTR, 1'b0, 1'b0, "R3 add prior acc");
    run_op(HALF, NHALF, NHALF, 1'b0, 1'b0, "R3 add negative acc");
    run_op(HALF, HALF, QTR, 1'b1, 1'b0, "R3 clear ignores acc");
    for (int i = 0; i < 4; i++) begin
      logic [63:0] r1, r2, r3;
      r1 = {$urandom(), $urandom()};
      r2 = {$urandom(), $urandom()};
      r3 = {$urandom(), 2'b00, $urandom()} >> 2;
      run_op(r1[W-1:0], r2[W-1:0], r3[W-1:0], 1'b0, 1'b0, "R3 mixed accumulate");
    end
  endtask

  task automatic t_round();
    run_op(ULP, HALF, '0, 1'b1, 1'b1, "R4 round up from half low");
    run_op('1, HALF, '0, 1'b1, 1'b1, "R4 round negative to zero");
    run_op(MAXP, MAXP, '0, 1'b1, 1'b1, "R4 round max*max");
    for (int i = 0; i < 3; i++) begin
      logic [63:0] r1, r2;
      r1 = {$urandom(), $urandom()};
      r2 = {$urandom(), $urandom()};
      run_op(r1[W-1:0], r2[W-1:0], QTR, i[0], 1'b1, "R4 mixed round");
    end
  endtask

  task automatic t_saturate();
    run_op(NEG1, NEG1, '0, 1'b1, 1'b0, "R5 -1*-1 saturates");
    run_op(NEG1, NEG1, '0, 1'b1, 1'b1, "R5 -1*-1 rounded saturates");
    run_op(MAXP, MAXP, MAXP, 1'b0, 1'b0, "R6 positive accumulate overflow");
    run_op(NEG1, MAXP, NEG1, 1'b0, 1'b0, "R6 negative accumulate overflow");
    run_op(HALF, HALF, '0, 1'b1, 1'b0, "R6 ovf clears on good result");
  endtask

  task automatic t_busy_ignore();
    logic [W-1:0] h0, l0;
    bit extra = 1'b0;
    @(negedge clk);
    drive(HALF, NHALF, '0, 1'b1, 1'b0);
    @(posedge clk); #1;
    start = 1'b0;
    repeat (10) @(posedge clk);
    #1;
    drive(QTR, QTR, MAXP, 1'b0, 1'b1);
    @(posedge clk); #1;
    start = 1'b0;
    for (int k = 12; k <= W + 1; k++) begin
      @(posedge clk); #1;
      if (k < W + 1 && done) extra = 1'b1;
    end
    check(done && !extra, "R8 single done at original time", {done, extra}, 2);
    check_result(HALF, NHALF, '0, 1'b1, 1'b0, "R8 first operands kept");
    h0 = acc_out; l0 = areg_out;
    for (int k = 0; k < W + 4; k++) begin
      @(posedge clk); #1;
      if (done || busy) extra = 1'b1;
    end
    check(!extra, "R8 no second operation started", {extra}, 0);
    check(acc_out == h0 && areg_out == l0, "R11 outputs hold while idle",
          {1'b0, acc_out, areg_out}, {1'b0, h0, l0});
  endtask

  task automatic t_back_to_back();
    logic [W-1:0] eh, el;
    logic eo;
    @(negedge clk);
    drive(QTR, HALF, '0, 1'b1, 1'b0);
    @(posedge clk); #1;
    start = 1'b0;
    wait_result("R10 first op");
    model(QTR, HALF, '0, 1'b1, 1'b0, eh, el, eo);
    check({acc_out, areg_out} == {eh, el}, "R10 first result at done",
          {1'b0, acc_out, areg_out}, {1'b0, eh, el});
    drive(NHALF, QTR, HALF, 1'b0, 1'b0);
    @(posedge clk); #1;
    start = 1'b0;
    check(busy && !done, "R10 start in done cycle accepted", {busy, done}, 2);
    wait_result("R10 second op");
    check_result(NHALF, QTR, HALF, 1'b0, 1'b0, "R10 second result");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(acc_out == '0 && !done && !busy && !ovf, "R1 outputs during reset",
          {acc_out, areg_out}, 0);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_products();
    t_accumulate();
    t_round();
    t_saturate();
    t_busy_ignore();
    t_back_to_back();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule